// File: doc/BRIEF.md
# Oscillator Frequency Meter

This block measures how fast an on-chip oscillator runs by timing it against a known reference clock. Software writes a window length, expressed as a number of oscillator cycles, and then sets a start bit. The meter first waits for an oscillator rising edge to mark the start. It then counts reference-clock cycles until the oscillator has produced that many further rising edges.

The final count is passed into the register clock domain and stored in a result register, and a valid flag is raised. Software converts the count into a frequency with `f_osc = f_ref * window / result`.

A separate free-run enable gates the oscillator into the counting logic. While that enable is low, no oscillator edges are seen, so no measurement can finish. The oscillator is sampled in the reference domain through a two-flop synchroniser, which assumes that each oscillator level lasts at least one reference period.

Three clock-related inputs are involved: the register-bus clock, the reference clock, and the oscillator level. The oscillator is treated as data.

Top module: `fm_meter`

## Requirements
- R1: After reset every register reads zero. The register map is as follows:
  - offset 0x00 is the control word: window length in bits 23:0, start enable in bit 24, both read/write.
  - offset 0x0C is the result register, read-only.
  - offset 0x10 is the status word: free-run enable in bit 8 (read/write) and the valid flag in bit 0 (read-only).
  - Unmapped offsets read zero.
- R2: With the free-run enable set, the result equals the number of reference cycles from one oscillator rising edge to the N-th rising edge after it, where N is the window length. For an oscillator period of P reference cycles, the result is N*P.
- R3: A window length of zero measures exactly as a window length of one.
- R4: The valid flag reads 1 only once the new result is readable. From that point the result register holds the finished count.
- R5: The valid flag stays at 1 while the start enable stays at 1. It reads 0 from the bus cycle after the write that clears the start enable.
- R6: Each 0-to-1 transition of the start enable begins a fresh measurement. For this to work, the enable must stay low for at least four reference cycles first. Directly after re-arming, valid reads 0, and it later rises with the new result.
- R7: While the free-run enable is 0, valid never asserts and the result register keeps its previous value.
- R8: Writes to the result register have no effect. The valid bit cannot be written through the status word.
- R9: The reference counter saturates at all ones of the result width instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Synchronous active-low reset, bus domain |
| ref_clk | input | 1 | Reference clock that is counted |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| osc_in | input | 1 | Level of the oscillator being measured |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The hardest state to reach is the end of a long window, where the count hits the top of the result width. The bench reaches it by building the block with a narrow result and running a window whose product of length and period exceeds that width.

A second hard case is a measurement that never completes because the free-run gate is closed. The bench holds the gate low with the start bit set for thousands of cycles, then reads back both status and result.

The oscillator is generated from the reference clock with an exact period in reference cycles. This makes every expected count an exact product.

// File: rtl/fm_pkg.sv
// Package: shared constants and types of the frequency meter.
// Assumes byte offsets on an 8-bit address and 32-bit data words.
package fm_pkg;
    localparam int ADDR_W    = 8;
    localparam int BUS_DW    = 32;
    localparam int WIN_W     = 24;
    localparam int EN_BIT    = 24;
    localparam int FRUN_BIT  = 8;
    localparam int VALID_BIT = 0;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RESULT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h10;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_ARM   = 2'd1,
        MS_COUNT = 2'd2,
        MS_DONE  = 2'd3
    } meas_state_e;
endpackage

// File: rtl/fm_sync2.sv
// Module: two-flop synchroniser for a vector of independent single-bit levels.
// Assumes each bit is a slow level; multi-bit values must not be passed through it.
module fm_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Purpose: shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fm_core.sv
// Module: reference-domain measurement engine.
// It waits for an oscillator rising edge, then counts reference cycles
// until win_len further edges have arrived, and holds the count with done
// high until the start enable drops.
// Assumes en_s, frun_s and osc_s are already synchronised to ref_clk, and
// that win_len is stable when en_s rises.
module fm_core #(
    parameter int WIN_W = 24,
    parameter int RES_W = 32
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             en_s,
    input  logic             frun_s,
    input  logic             osc_s,
    input  logic [WIN_W-1:0] win_len,
    output logic [RES_W-1:0] result,
    output logic             done
);
    import fm_pkg::*;

    localparam logic [RES_W-1:0] RES_MAX = '1;
    localparam logic [WIN_W-1:0] WIN_ONE = WIN_W'(1);

    meas_state_e      state;
    logic             en_q;
    logic             gated_q;
    logic [WIN_W-1:0] target;
    logic [WIN_W-1:0] edges;
    logic [RES_W-1:0] refcnt;

    logic             gated;
    logic             osc_rise;
    logic             start;
    logic [WIN_W-1:0] edges_nxt;
    logic [RES_W-1:0] refcnt_inc;

    assign gated      = osc_s & frun_s;
    assign osc_rise   = gated & ~gated_q;
    assign start      = en_s & ~en_q;
    assign edges_nxt  = edges + WIN_ONE;
    assign refcnt_inc = (refcnt == RES_MAX) ? refcnt : refcnt + 1'b1;
    assign done       = (state == MS_DONE);

    // Purpose: delayed copies used for edge detection.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            en_q    <= 1'b0;
            gated_q <= 1'b0;
        end else begin
            en_q    <= en_s;
            gated_q <= gated;
        end
    end

    // Purpose: measurement sequence and counters.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            state  <= MS_IDLE;
            target <= WIN_ONE;
            edges  <= '0;
            refcnt <= '0;
            result <= '0;
        end else if (!en_s) begin
            state <= MS_IDLE;
        end else begin
            case (state)
                MS_IDLE: begin
                    if (start) begin
                        state  <= MS_ARM;
                        target <= (win_len == '0) ? WIN_ONE : win_len;
                    end
                end
                MS_ARM: begin
                    if (osc_rise) begin
                        state  <= MS_COUNT;
                        refcnt <= '0;
                        edges  <= '0;
                    end
                end
                MS_COUNT: begin
                    refcnt <= refcnt_inc;
                    if (osc_rise) begin
                        edges <= edges_nxt;
                        if (edges_nxt == target) begin
                            state  <= MS_DONE;
                            result <= refcnt_inc;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: an active window never has a zero length.
    assert_window_floor_R3: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (state == MS_COUNT) |-> (target != '0 && edges < target));

    // R7: with the gate closed, no oscillator edge can start counting.
    assert_gate_closed_R7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (state == MS_ARM && !frun_s) |=> (state != MS_COUNT));

    // R5: dropping the enable releases done.
    assert_done_release_R5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !en_s |=> !done);

    // R4: the finished count is stable while it is offered.
    assert_result_hold_R4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (done && en_s) |=> $stable(result));

    // R9: the counter never wraps back to zero while counting.
    assert_no_wrap_R9: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (state == MS_COUNT && en_s) |=> (refcnt != '0));
endmodule

// File: rtl/fm_regs.sv
// Module: bus-domain register file.
// It holds the control word and the free-run enable. It captures the result
// on the rising edge of the synchronised done level and keeps a sticky valid flag.
// Assumes the result from the reference domain is stable while done is high,
// and that RES_W <= DW.
module fm_regs #(
    parameter int ADDR_W = 8,
    parameter int DW     = 32,
    parameter int WIN_W  = 24,
    parameter int RES_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [RES_W-1:0]  core_result,
    input  logic              done_s,
    output logic [WIN_W-1:0]  win_len,
    output logic              meas_en,
    output logic              frun_en
);
    import fm_pkg::*;

    logic [RES_W-1:0] result_q;
    logic             valid;
    logic             done_q;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    // Purpose: software writes to the control word and the free-run enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_len <= '0;
            meas_en <= 1'b0;
            frun_en <= 1'b0;
        end else if (wr_en) begin
            if (addr == OFS_CTRL) begin
                win_len <= wdata[WIN_W-1:0];
                meas_en <= wdata[EN_BIT];
            end
            if (addr == OFS_STATUS) begin
                frun_en <= wdata[FRUN_BIT];
            end
        end
    end

    // Purpose: capture the finished count and manage the sticky valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            valid    <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= done_s;
            if (!meas_en) begin
                valid <= 1'b0;
            end else if (done_s && !done_q) begin
                valid    <= 1'b1;
                result_q <= core_result;
            end
        end
    end

    // Purpose: read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[WIN_W-1:0] = win_len;
                rdata[EN_BIT]    = meas_en;
            end
            OFS_RESULT: rdata[RES_W-1:0] = result_q;
            OFS_STATUS: begin
                rdata[FRUN_BIT]  = frun_en;
                rdata[VALID_BIT] = valid;
            end
            default: ;
        endcase
    end

    // R5: clearing the enable clears valid on the next edge.
    assert_valid_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> !valid);

    // R4: valid rises only after the synchronised done has been seen.
    assert_valid_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(done_s));
endmodule

// File: rtl/fm_meter.sv
// Module: top of the frequency meter.
// It joins the bus register file and the reference-domain engine through
// two-flop synchronisers in each direction.
// Assumes each oscillator level lasts at least one reference period, and that
// software keeps the start enable low for four reference cycles between runs.
module fm_meter #(
    parameter int RES_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ref_clk,
    input  logic                      ref_rst_n,
    input  logic                      osc_in,
    input  logic                      wr_en,
    input  logic [fm_pkg::ADDR_W-1:0] addr,
    input  logic [fm_pkg::BUS_DW-1:0] wdata,
    output logic [fm_pkg::BUS_DW-1:0] rdata
);
    import fm_pkg::*;

    logic [WIN_W-1:0] win_len;
    logic             meas_en;
    logic             frun_en;
    logic             en_s;
    logic             frun_s;
    logic             osc_s;
    logic [RES_W-1:0] core_result;
    logic             done_ref;
    logic             done_s;

    fm_regs #(
        .ADDR_W(ADDR_W), .DW(BUS_DW), .WIN_W(WIN_W), .RES_W(RES_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .core_result(core_result),
        .done_s(done_s), .win_len(win_len), .meas_en(meas_en),
        .frun_en(frun_en)
    );

    fm_sync2 #(.W(3)) u_to_ref (
        .clk(ref_clk), .rst_n(ref_rst_n),
        .d({meas_en, frun_en, osc_in}),
        .q({en_s, frun_s, osc_s})
    );

    fm_core #(.WIN_W(WIN_W), .RES_W(RES_W)) u_core (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .en_s(en_s),
        .frun_s(frun_s), .osc_s(osc_s), .win_len(win_len),
        .result(core_result), .done(done_ref)
    );

    fm_sync2 #(.W(1)) u_to_bus (
        .clk(clk), .rst_n(rst_n), .d(done_ref), .q(done_s)
    );
endmodule

// File: tb/tb_fm_meter.sv
module tb_fm_meter;
    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 14;
    localparam int RES_W      = 12;
    localparam int RES_MAX    = (1 << RES_W) - 1;
    localparam int WATCHDOG   = 150000;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_RES  = 8'h0C;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_NONE = 8'h04;
    localparam logic [31:0] EN    = 32'h0100_0000;
    localparam logic [31:0] FRUN  = 32'h0000_0100;

    logic        clk = 0, ref_clk = 0, rst_n = 0, ref_rst_n = 0;
    logic        wr_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        osc_in;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;
    int osc_period = 4;
    int osc_cnt = 0;

    fm_meter #(.RES_W(RES_W)) dut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .osc_in(osc_in), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    // Oscillator model: rising edges exactly osc_period reference cycles apart.
    always @(negedge ref_clk) begin
        if (osc_cnt + 1 >= osc_period) osc_cnt <= 0;
        else osc_cnt <= osc_cnt + 1;
    end
    assign osc_in = (osc_cnt < osc_period / 2);

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected <%0d cycles", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; wdata = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_valid(input int limit, output bit got);
        logic [31:0] s;
        got = 0;
        for (int i = 0; i < limit; i++) begin
            bus_rd(A_STAT, s);
            if (s[0]) begin got = 1; break; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Runs one measurement and checks the result against min(max(n,1)*p, RES_MAX).
    task automatic measure(input string req, input int n, input int p);
        logic [31:0] d;
        bit got;
        int expv;
        osc_period = p;
        idle(3 * p + 10);
        expv = ((n == 0) ? 1 : n) * p;
        if (expv > RES_MAX) expv = RES_MAX;
        bus_wr(A_CTRL, 32'(n));
        idle(10);
        bus_wr(A_CTRL, 32'(n) | EN);
        bus_rd(A_STAT, d);
        check({req, " R6 valid low after re-arm"}, {31'b0, d[0]}, 32'h0);
        wait_valid(40000, got);
        check({req, " R4 valid reached"}, {31'b0, got}, 32'h1);
        bus_rd(A_RES, d);
        check({req, " R2 result"}, d, 32'(expv));
    endtask

    initial begin
        logic [31:0] d;
        idle(5);
        rst_n = 1; ref_rst_n = 1;
        idle(2);

        // R1: reset values and the unmapped offset.
        bus_rd(A_CTRL, d); check("R1 ctrl reset", d, 32'h0);
        bus_rd(A_RES, d);  check("R1 result reset", d, 32'h0);
        bus_rd(A_STAT, d); check("R1 status reset", d, 32'h0);
        bus_rd(A_NONE, d); check("R1 unmapped", d, 32'h0);
        bus_wr(A_CTRL, 32'h00AB_CDEF);
        bus_rd(A_CTRL, d); check("R1 ctrl readback", d, 32'h00AB_CDEF);
        bus_wr(A_STAT, FRUN);
        bus_rd(A_STAT, d); check("R1 status readback", d, FRUN);

        // R2, R4: basic window of 5 with period 6.
        measure("R2 n5p6", 5, 6);

        // R5: valid remains while enabled.
        idle(200);
        bus_rd(A_STAT, d); check("R5 valid sticky", d, FRUN | 32'h1);

        // R8: result and valid are not writable.
        bus_wr(A_RES, 32'h0000_05A5);
        bus_rd(A_RES, d); check("R8 result write ignored", d, 32'd30);
        bus_wr(A_STAT, FRUN);
        bus_rd(A_STAT, d); check("R8 valid not cleared by write", d, FRUN | 32'h1);

        // R5: clearing the enable clears valid.
        bus_wr(A_CTRL, 32'd5);
        bus_rd(A_STAT, d); check("R5 valid cleared", d, FRUN);
        bus_rd(A_RES, d); check("R5 result kept", d, 32'd30);
        idle(10);

        // R8: writing bit 0 of status while idle does not set valid.
        bus_wr(A_STAT, FRUN | 32'h1);
        bus_rd(A_STAT, d); check("R8 valid not set by write", d, FRUN);

        // R2, R6: nominal window of 1024, then other windows.
        measure("R6 n1024p3", 1024, 3);
        bus_wr(A_CTRL, 32'd0); idle(10);
        measure("R3 n0p7", 0, 7);
        bus_wr(A_CTRL, 32'd0); idle(10);
        measure("R6 n7p5", 7, 5);
        bus_wr(A_CTRL, 32'd0); idle(10);

        // R7: gate closed, no valid and result kept.
        bus_wr(A_STAT, 32'h0);
        idle(10);
        bus_wr(A_CTRL, 32'd2 | EN);
        idle(3000);
        bus_rd(A_STAT, d); check("R7 no valid while gated", d, 32'h0);
        bus_rd(A_RES, d); check("R7 result unchanged", d, 32'd35);
        bus_wr(A_CTRL, 32'd2);
        bus_wr(A_STAT, FRUN);
        idle(10);

        // R9: saturation of the count at the result width.
        measure("R9 saturate", 300, 16);
        bus_wr(A_CTRL, 32'd0);
        idle(10);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule